// File: doc/BRIEF.md
# Two-Digit Decimal Delay Timer

This block delays an event by exactly one hundred steps of an external time base. It is built from two 4-bit decimal digit counters in a chain. A trigger clears both digits and starts the run. Each time-base enable then advances the low digit. The high digit advances only when the low digit rolls over from nine to zero.

The run ends on the natural rollover of the pair from 99 to 00, so no magnitude comparator is needed. That rollover raises a one-clock completion pulse and stops the count. Each digit has a combinational flag that marks the six codes that are not decimal.

A parallel load can place any 4-bit code in either digit. A digit holding one of the non-decimal codes goes to zero on its next counting step and carries into the next digit, as if it had passed nine.

Top module: `bcd_delay_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, both digits, `done_o` and the running state are cleared. After reset, time-base enables do not move the digits until a trigger arrives.
- R2: A trigger sets both digits to 00 at the next edge and starts the run. It takes priority over a load and over a time-base enable in the same cycle.
- R3: While running, each cycle with `tick_en` high advances the low digit (`digits_o[3:0]`) by one. Cycles with `tick_en` low leave the digits unchanged.
- R4: The high digit (`digits_o[7:4]`) advances only on a step in which the low digit goes from 9 to 0.
- R5: `done_o` is high for exactly one clock, in the cycle after the 100th counted tick that follows a trigger. At that point the digits read 00. Later ticks leave the digits at 00 until the next trigger.
- R6: `invalid_o[i]` equals bit3 AND (bit2 OR bit1) of digit i. It is high for codes 10 to 15 and low for codes 0 to 9, with no register in the path.
- R7: A load without a trigger writes `load_digits[3:0]` to the low digit and `load_digits[7:4]` to the high digit, any code accepted. It takes priority over a tick in the same cycle and does not change the running state.
- R8: A digit holding a code from 10 to 15 becomes 0 on its next counting step and carries into the next digit. A carry out of the high digit ends the run exactly as a 99-to-00 wrap does.
- R9: When a trigger falls in the same cycle as the tick that would wrap 99 to 00, no done pulse is produced. The digits read 00 and the run continues from 00.
- R10: While idle, neither ticks nor the absence of a load change the digits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time-base enable; one counting step per high cycle while running |
| trigger | input | 1 | Clears the digits and starts a run |
| load_en | input | 1 | Parallel load strobe |
| load_digits | input | 8 | Load value, high digit in [7:4], low digit in [3:0] |
| digits_o | output | 8 | Current digits, high in [7:4], low in [3:0] |
| done_o | output | 1 | One-clock pulse on the terminal wrap |
| invalid_o | output | 2 | Per-digit non-decimal flag, bit i for digit i |

## Verification
Two events can land on the same edge: a trigger and the tick that wraps the count from 99 to 00. The bench loads 99 while a run is active, then raises the trigger and the tick together. A correct result has the digits at 00, no done pulse in either following cycle, and the next tick reading 01 because the run continues. Trigger against load and load against tick are provoked the same way and judged by the digits read one edge later.

// File: rtl/bcd_timer_pkg.sv
package bcd_timer_pkg;
    localparam int DIGIT_W    = 4;
    localparam int DIGIT_MAX  = 9;

    typedef struct packed {
        logic running;
        logic done;
    } ctrl_state_t;
endpackage

// File: rtl/bcd_invalid_detect.sv
module bcd_invalid_detect #(
    parameter int W = 4
) (
    input  logic [W-1:0] code_i,
    output logic         invalid_o
);
    // Two levels: an OR of the middle bits feeding an AND with the top bit.
    always_comb begin
        invalid_o = code_i[W-1] & (code_i[W-2] | code_i[W-3]);
    end
endmodule

// File: rtl/bcd_digit_counter.sv
module bcd_digit_counter #(
    parameter int W    = 4,
    parameter int MAXV = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         en_i,
    output logic [W-1:0] val_o,
    output logic         carry_o
);
    localparam logic [W-1:0] TOP = W'(MAXV);

    typedef struct packed {
        logic [W-1:0] val;
    } digit_state_t;

    digit_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        carry_o = 1'b0;
        if (clr_i) begin
            st_d.val = '0;
        end else if (ld_i) begin
            st_d.val = ld_val_i;
        end else if (en_i) begin
            if (st_q.val >= TOP) begin
                st_d.val = '0;
                carry_o  = 1'b1;
            end else begin
                st_d.val = st_q.val + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o = st_q.val;

    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (val_o == '0));
    a_r3_step_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !ld_i && val_o < TOP) |=> (val_o == $past(val_o) + 1'b1));
    a_r8_bad_code_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !ld_i && val_o > TOP) |=> (val_o == '0));
    a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && !clr_i) |=> (val_o == $past(ld_val_i)));
endmodule

// File: rtl/bcd_run_ctrl.sv
module bcd_run_ctrl
    import bcd_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic trigger_i,
    input  logic load_i,
    input  logic wrap_i,
    output logic count_en_o,
    output logic done_o
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        count_en_o  = st_q.running & tick_i & ~trigger_i & ~load_i;
        st_d        = st_q;
        st_d.done   = wrap_i;
        if (trigger_i)   st_d.running = 1'b1;
        else if (wrap_i) st_d.running = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r5_done_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !st_q.running);
    a_r9_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        trigger_i |=> (st_q.running && !done_o));
    a_r1_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.running |-> !count_en_o);
endmodule

// File: rtl/bcd_delay_timer.sv
module bcd_delay_timer
    import bcd_timer_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_en,
    input  logic                          trigger,
    input  logic                          load_en,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] load_digits,
    output logic [NUM_DIGITS*DIGIT_W-1:0] digits_o,
    output logic                          done_o,
    output logic [NUM_DIGITS-1:0]         invalid_o
);
    localparam int BUS_W = NUM_DIGITS * DIGIT_W;

    logic [NUM_DIGITS:0] chain_en;
    logic                count_en;

    assign chain_en[0] = count_en;

    genvar g;
    generate
        for (g = 0; g < NUM_DIGITS; g++) begin : g_digit
            bcd_digit_counter #(
                .W    (DIGIT_W),
                .MAXV (DIGIT_MAX)
            ) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr_i    (trigger),
                .ld_i     (load_en),
                .ld_val_i (load_digits[g*DIGIT_W +: DIGIT_W]),
                .en_i     (chain_en[g]),
                .val_o    (digits_o[g*DIGIT_W +: DIGIT_W]),
                .carry_o  (chain_en[g+1])
            );

            bcd_invalid_detect #(
                .W (DIGIT_W)
            ) u_inv (
                .code_i    (digits_o[g*DIGIT_W +: DIGIT_W]),
                .invalid_o (invalid_o[g])
            );

            a_r6_flag_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
                invalid_o[g] == (digits_o[g*DIGIT_W +: DIGIT_W] > DIGIT_W'(DIGIT_MAX)));
        end
    endgenerate

    bcd_run_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_en),
        .trigger_i  (trigger),
        .load_i     (load_en),
        .wrap_i     (chain_en[NUM_DIGITS]),
        .count_en_o (count_en),
        .done_o     (done_o)
    );

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !trigger && !load_en) |=> $stable(digits_o));
    a_r5_done_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (digits_o == BUS_W'(0)));
endmodule

// File: tb/bcd_delay_timer_tb_top.sv
module bcd_delay_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       trigger = 1'b0;
    logic       load_en = 1'b0;
    logic [7:0] load_digits = 8'h00;
    logic [7:0] digits_o;
    logic       done_o;
    logic [1:0] invalid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bcd_delay_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .trigger     (trigger),
        .load_en     (load_en),
        .load_digits (load_digits),
        .digits_o    (digits_o),
        .done_o      (done_o),
        .invalid_o   (invalid_o)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [7:0] exp_d, input logic exp_done);
        check(digits_o === exp_d, req, digits_o, exp_d);
        check(done_o === exp_done, {req, " done"}, {7'd0, done_o}, {7'd0, exp_done});
    endtask

    task automatic cyc(input logic t, input logic tr, input logic ld, input logic [7:0] v);
        @(negedge clk);
        tick_en = t; trigger = tr; load_en = ld; load_digits = v;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] to_bcd(input int k);
        return {4'((k / 10) % 10), 4'(k % 10)};
    endfunction

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 0, 8'h00);
        chk_state("R1 reset", 8'h00, 1'b0);
        check(invalid_o === 2'b00, "R1 invalid", {6'd0, invalid_o}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 8'h00);
        chk_state("R1 no count before trigger", 8'h00, 1'b0);
        chk_state("R10 idle ticks", 8'h00, 1'b0);
    endtask

    task automatic t_full_run;
        cyc(0, 1, 0, 8'h00);
        chk_state("R2 trigger clears", 8'h00, 1'b0);
        for (int k = 1; k <= 100; k++) begin
            if (k % 7 == 0) begin
                cyc(0, 0, 0, 8'h00);
                chk_state("R3 gap holds", to_bcd(k - 1), 1'b0);
            end
            cyc(1, 0, 0, 8'h00);
            if (k == 10)       chk_state("R4 high digit on 9->0", 8'h10, 1'b0);
            else if (k == 100) chk_state("R5 done on wrap", 8'h00, 1'b1);
            else               chk_state("R3 step", to_bcd(k), 1'b0);
        end
        cyc(1, 0, 0, 8'h00);
        chk_state("R5 done one clock", 8'h00, 1'b0);
        cyc(1, 0, 0, 8'h00);
        chk_state("R5 stopped after wrap", 8'h00, 1'b0);
    endtask

    task automatic t_invalid_flags;
        for (int c = 0; c < 16; c++) begin
            cyc(0, 0, 1, {4'(c), 4'(15 - c)});
            check(invalid_o[0] === (15 - c >= 10), "R6 low flag", {7'd0, invalid_o[0]}, 8'(15 - c >= 10));
            check(invalid_o[1] === (c >= 10), "R6 high flag", {7'd0, invalid_o[1]}, 8'(c >= 10));
        end
    endtask

    task automatic t_recover;
        cyc(0, 1, 0, 8'h00);
        cyc(1, 0, 1, 8'h3C);
        chk_state("R7 load over tick", 8'h3C, 1'b0);
        check(invalid_o === 2'b01, "R6 low bad", {6'd0, invalid_o}, 8'h01);
        cyc(1, 0, 0, 8'h00);
        chk_state("R8 low bad code carries", 8'h40, 1'b0);
        cyc(0, 0, 1, 8'hF5);
        cyc(1, 0, 0, 8'h00);
        chk_state("R8 high bad code no step", 8'hF6, 1'b0);
        cyc(0, 0, 1, 8'hA9);
        cyc(1, 0, 0, 8'h00);
        chk_state("R8 high bad code wraps", 8'h00, 1'b1);
        cyc(1, 0, 0, 8'h00);
        chk_state("R8 run ended", 8'h00, 1'b0);
    endtask

    task automatic t_same_cycle;
        cyc(0, 1, 0, 8'h00);
        cyc(0, 0, 1, 8'h99);
        chk_state("R7 load while running", 8'h99, 1'b0);
        cyc(1, 1, 0, 8'h00);
        chk_state("R9 trigger with wrap tick", 8'h00, 1'b0);
        cyc(0, 0, 0, 8'h00);
        chk_state("R9 no late done", 8'h00, 1'b0);
        cyc(1, 0, 0, 8'h00);
        chk_state("R9 run continues", 8'h01, 1'b0);
        cyc(1, 1, 1, 8'h55);
        chk_state("R2 trigger over load", 8'h00, 1'b0);
        cyc(1, 0, 0, 8'h00);
        chk_state("R2 running after trigger", 8'h01, 1'b0);
    endtask

    task automatic t_idle_load;
        cyc(0, 0, 1, 8'h99);
        cyc(1, 0, 0, 8'h00);
        chk_state("R5 wrap from loaded 99", 8'h00, 1'b1);
        cyc(0, 0, 1, 8'h42);
        chk_state("R7 load while idle", 8'h42, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 8'h00);
        chk_state("R10 idle ticks after load", 8'h42, 1'b0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_full_run();
        t_invalid_flags();
        t_recover();
        t_same_cycle();
        t_idle_load();
        finished = 1'b1;
        summary();
    end

    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end
endmodule